// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check Phase

This block is a compact 16-bit processor with a single accumulator. It steps through a fixed sequence for each instruction. First it reads the word at the program counter into the instruction register and advances the counter. Then it carries out the instruction against a synchronous, word-addressed memory port. The sequence closes with a dedicated phase that samples the interrupt request. The memory port is external, so the surrounding logic supplies program and data storage with a one-cycle read latency.

When a request is pending and no handler is active, the interrupt phase takes it. It pulses an acknowledge, copies the program counter and accumulator into shadow registers, marks a handler as running and redirects fetch to a fixed handler address. A return instruction copies both shadow values back and clears the running mark. Requests are handled one after another, never nested. A request that arrives while a handler runs is held and is taken in the check phase of the return instruction itself.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries its opcode in bits [15:12] and a 12-bit memory address in bits [11:0]. A data word carries its sign in bit 15 (1 = negative) and its magnitude in bits [14:0]. The opcodes are:
  - 4'h1 loads the accumulator.
  - 4'h2 stores the accumulator.
  - 4'h5 adds the memory word to the accumulator.
  - 4'h0 halts.
  - 4'hF returns from a handler.
  - Every other opcode executes as a no-op that neither writes memory nor changes the accumulator.
- R2: An active-low asynchronous reset clears the program counter, accumulator, pending request and handler-running flag. While in reset and on the first cycle after it, the memory address is 0, and write enable and acknowledge are low.
- R3: Each instruction is fetched from the program counter address, and the counter then advances by one. Read data is expected one cycle after the address. A load places the addressed word in the accumulator.
- R4: A store drives the accumulator onto the write data with a single-cycle write enable at the instruction's address. Write enable and acknowledge are never high together.
- R5: The add works in sign-magnitude form:
  - When the signs match, the magnitudes are summed, the sum is truncated to 15 bits and the common sign is kept.
  - When the signs differ, the smaller magnitude is taken from the larger one and the sign of the larger is kept.
  - A zero result from differing signs is positive.
- R6: After a halt the processor stays stopped until reset. The address output holds the halt's address plus one, no further writes occur, and requests are not acknowledged.
- R7: At the end of every instruction, a pending request with no handler running is taken. The acknowledge is high for exactly one cycle, and the next fetch address is 0x0F0.
- R8: The return instruction restores the saved program counter and accumulator and clears the handler-running flag, so the interrupted program finishes with the same result as an uninterrupted run.
- R9: Requests arriving while a handler runs are held, and several such requests merge into one. The held request is acknowledged in the check phase of the return instruction itself, so the acknowledges are exactly one handler duration apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the address |
| irq_i | input | 1 | Interrupt request (a single-cycle pulse is enough) |
| irq_ack_o | output | 1 | Interrupt taken, one-cycle pulse |
| halted_o | output | 1 | Processor stopped by a halt instruction |

## Verification
The hardest condition to reach is a request that lands while a handler is already running. It must be held, merged with any later requests, and taken in the check phase of the return instruction, exactly one handler duration after the first acknowledge. The stimulus gets there by waiting for the first acknowledge and then pulsing the request twice inside the handler. It then checks that there are two handler entries in total and an acknowledge spacing of exactly 18 cycles. Request pulses at random times during a program that adds repeatedly confirm that every entry is matched by a restored context. The final sum must equal the uninterrupted result.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OP_W-1:0] OP_RETI  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LATCH,
    ST_EXEC,
    ST_OPND,
    ST_ICHK,
    ST_HALT
  } state_e;
endpackage

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned MW = W - 1;

  logic          sa, sb, sgn, a_ge;
  logic [MW-1:0] ma, mb, mag;

  always_comb begin
    sa   = a_i[W-1];
    sb   = b_i[W-1];
    ma   = a_i[MW-1:0];
    mb   = b_i[MW-1:0];
    a_ge = (ma >= mb);
    if (sa == sb) begin
      mag = ma + mb;  // carry out dropped
      sgn = sa;
    end else if (a_ge) begin
      mag = ma - mb;
      sgn = sa;
    end else begin
      mag = mb - ma;
      sgn = sb;
    end
    if ((sa != sb) && (mag == '0)) sgn = 1'b0;
    sum_o = {sgn, mag};
  end
endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              check_i,
  input  logic              reti_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              take_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic [DATA_W-1:0] ret_acc_o
);
  logic              pending_q, busy_q;
  logic [ADDR_W-1:0] sh_pc_q;
  logic [DATA_W-1:0] sh_acc_q;

  assign take_o    = check_i & ~busy_q & (pending_q | irq_i);
  assign busy_o    = busy_q;
  assign ret_pc_o  = sh_pc_q;
  assign ret_acc_o = sh_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      sh_pc_q   <= '0;
      sh_acc_q  <= '0;
    end else begin
      // Requests merge into a single pending bit
      if (take_o)     pending_q <= 1'b0;
      else if (irq_i) pending_q <= 1'b1;

      if (take_o) begin
        busy_q   <= 1'b1;
        sh_pc_q  <= pc_i;
        sh_acc_q <= acc_i;
      end else if (reti_i) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output state_e          state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH: state_d = ST_LATCH;
      ST_LATCH: state_d = ST_EXEC;
      ST_EXEC: begin
        case (opcode_i)
          OP_LOAD, OP_ADD: state_d = ST_OPND;
          OP_HALT:         state_d = ST_HALT;
          default:         state_d = ST_ICHK;
        endcase
      end
      ST_OPND: state_d = ST_ICHK;
      ST_ICHK: state_d = ST_FETCH;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned VECTOR = 'h0F0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [DATA_W-OP_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  output logic                     mem_we_o,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  input  logic                     irq_i,
  output logic                     irq_ack_o,
  output logic                     halted_o
);
  localparam int unsigned ADDR_W = DATA_W - OP_W;
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VECTOR);

  state_e            state;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q, acc_q, sum;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] oper_addr;
  logic              is_reti, take, irq_busy;
  logic [ADDR_W-1:0] ret_pc;
  logic [DATA_W-1:0] ret_acc;

  assign opcode    = ir_q[DATA_W-1 -: OP_W];
  assign oper_addr = ir_q[ADDR_W-1:0];
  assign is_reti   = (state == ST_EXEC) && (opcode == OP_RETI);

  acc_cpu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .state_o  (state)
  );

  acc_cpu_irq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .check_i   (state == ST_ICHK),
    .reti_i    (is_reti),
    .pc_i      (pc_q),
    .acc_i     (acc_q),
    .take_o    (take),
    .busy_o    (irq_busy),
    .ret_pc_o  (ret_pc),
    .ret_acc_o (ret_acc)
  );

  acc_cpu_smadd #(.W(DATA_W)) u_add (
    .a_i   (acc_q),
    .b_i   (mem_rdata_i),
    .sum_o (sum)
  );

  always_comb begin
    mem_addr_o  = (state == ST_EXEC) ? oper_addr : pc_q;
    mem_wdata_o = acc_q;
    mem_we_o    = (state == ST_EXEC) && (opcode == OP_STORE);
    irq_ack_o   = take;
    halted_o    = (state == ST_HALT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      case (state)
        ST_LATCH: begin
          ir_q <= mem_rdata_i;
          pc_q <= pc_q + ADDR_W'(1);
        end
        ST_EXEC: begin
          if (is_reti) begin
            pc_q  <= ret_pc;
            acc_q <= ret_acc;
          end
        end
        ST_OPND: acc_q <= (opcode == OP_ADD) ? sum : mem_rdata_i;
        ST_ICHK: if (take) pc_q <= VEC_ADDR;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned VECTOR = 'h0F0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              irq_ack_o,
  input logic              halted_o,
  input logic              busy_i
);
  assert_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (mem_addr_o == ADDR_W'(VECTOR)));

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  assert_busy_after_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> busy_i);

  assert_busy_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(irq_ack_o));

  assert_we_ack_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && irq_ack_o));

  assert_halt_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(mem_addr_o) && !mem_we_o && !irq_ack_o));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .irq_ack_o  (irq_ack_o),
  .halted_o   (halted_o),
  .busy_i     (irq_busy)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int MW = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, irq, irq_ack, halted;

  logic [15:0] mem [0:MW-1];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  int acks = 0, last_ack = 0, last_gap = 0;
  bit ack_prev = 0, done = 0;

  always #2 clk = ~clk;

  acc_cpu dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .irq_i(irq), .irq_ack_o(irq_ack),
    .halted_o(halted)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ack monitor: counts acks, measures spacing, checks the vector fetch (R7)
  always @(negedge clk) begin
    if (ack_prev) check(mem_addr == 12'h0F0, "R7 vector fetch", mem_addr, 12'h0F0);
    ack_prev = 0;
    if (rst_ni && irq_ack) begin
      acks++;
      last_gap = cyc - last_ack;
      last_ack = cyc;
      ack_prev = 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
    int va, vb, s, m;
    logic sg;
    va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    s  = va + vb;
    if (s < 0) begin sg = 1'b1; m = -s; end
    else       begin sg = 1'b0; m = s;  end
    if (s == 0 && a[15] == b[15]) sg = a[15];
    return {sg, 15'(m)};
  endfunction

  task automatic poke(input int a, input logic [15:0] d);
    ld_addr = 12'(a);
    ld_data = d;
    ld_en   = 1'b1;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic begin_load();
    @(negedge clk);
    rst_ni = 1'b0;
    irq    = 1'b0;
    acks   = 0;
    for (int i = 0; i < 512; i++) poke(i, 16'h0000);
  endtask

  task automatic start();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_halt(input int limit);
    int n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  // Arithmetic program: R1, R3, R4, R5, R6
  task automatic run_arith(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp;
    begin_load();
    poke(0, ins(4'h1, 12'h100));
    poke(1, ins(4'h2, 12'h103));
    poke(2, ins(4'h5, 12'h101));
    poke(3, ins(4'h7, 12'h103));  // no-op opcode
    poke(4, ins(4'h2, 12'h102));
    poke(5, ins(4'h0, 12'h000));
    poke(12'h100, a);
    poke(12'h101, b);
    start();
    wait_halt(200);
    exp = ref_add(a, b);
    check(halted === 1'b1, "R6 halted", halted, 1);
    check(mem[12'h103] == a, "R3 R4 load/store copy, R1 no-op", mem[12'h103], a);
    check(mem[12'h102] == exp, "R5 add result", mem[12'h102], exp);
  endtask

  task automatic load_int_prog(input logic [15:0] a, input logic [15:0] b);
    begin_load();
    poke(0, ins(4'h1, 12'h100));
    for (int i = 1; i <= 8; i++) poke(i, ins(4'h5, 12'h101));
    poke(9, ins(4'h2, 12'h102));
    poke(10, ins(4'h0, 12'h000));
    poke(12'h0F0, ins(4'h1, 12'h120));
    poke(12'h0F1, ins(4'h5, 12'h121));
    poke(12'h0F2, ins(4'h2, 12'h120));
    poke(12'h0F3, ins(4'hF, 12'h000));
    poke(12'h100, a);
    poke(12'h101, b);
    poke(12'h121, 16'h0001);
  endtask

  function automatic logic [15:0] int_expect(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] e = a;
    for (int k = 0; k < 8; k++) e = ref_add(e, b);
    return e;
  endfunction

  initial begin
    logic [15:0] ra, rb;
    int np;
    irq = 1'b0;
    void'($urandom(32'd4711));

    // R2: reset state
    begin_load();
    poke(0, ins(4'h0, 12'h000));
    check(mem_addr == 12'h000, "R2 reset addr", mem_addr, 0);
    check(mem_we == 1'b0 && irq_ack == 1'b0 && halted == 1'b0, "R2 reset outputs",
          {mem_we, irq_ack, halted}, 0);
    start();
    check(mem_addr == 12'h000 && mem_we == 1'b0, "R2 first fetch addr", mem_addr, 0);

    // R5 directed corners
    run_arith(16'h0005, 16'h0003);
    run_arith(16'h0005, 16'h8003);
    run_arith(16'h8005, 16'h0003);
    run_arith(16'h0004, 16'h8004);
    run_arith(16'h7FFF, 16'h0001);
    run_arith(16'h8000, 16'h8000);
    run_arith(16'hC000, 16'hC000);

    // R6: halt persistence and ignored requests
    repeat (10) @(negedge clk);
    check(halted == 1'b1 && mem_addr == 12'h006, "R6 halt holds addr", mem_addr, 6);
    pulse_irq();
    repeat (5) @(negedge clk);
    check(acks == 0, "R6 no ack while halted", acks, 0);

    // R5 random operands
    for (int t = 0; t < 12; t++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      run_arith(ra, rb);
    end

    // R7 R8: single interrupt preserves the main program
    ra = 16'h0010; rb = 16'h0003;
    load_int_prog(ra, rb);
    start();
    repeat (12) @(negedge clk);
    pulse_irq();
    wait_halt(800);
    check(acks == 1, "R7 one ack", acks, 1);
    check(mem[12'h120] == 16'd1, "R7 handler entered", mem[12'h120], 1);
    check(mem[12'h102] == int_expect(ra, rb), "R8 context restored", mem[12'h102],
          int_expect(ra, rb));

    // R9: requests during a handler merge and are taken at its return
    ra = 16'h8020; rb = 16'h0005;
    load_int_prog(ra, rb);
    start();
    repeat (8) @(negedge clk);
    pulse_irq();
    while (acks == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    pulse_irq();
    repeat (2) @(negedge clk);
    pulse_irq();
    wait_halt(800);
    check(acks == 2, "R9 merged pending ack count", acks, 2);
    check(last_gap == 18, "R9 ack spacing equals handler length", last_gap, 18);
    check(mem[12'h120] == 16'd2, "R9 handler entries", mem[12'h120], 2);
    check(mem[12'h102] == int_expect(ra, rb), "R8 result after two entries",
          mem[12'h102], int_expect(ra, rb));

    // R7 R8 R9: random request timing
    for (int t = 0; t < 10; t++) begin
      ra = 16'($urandom);
      rb = 16'($urandom) & 16'h83FF;
      np = int'($urandom % 4);
      load_int_prog(ra, rb);
      start();
      fork
        begin
          for (int p = 0; p < np; p++) begin
            repeat (int'($urandom % 25)) @(negedge clk);
            pulse_irq();
          end
        end
        wait_halt(1500);
      join
      wait_halt(1500);
      check(halted == 1'b1, "R6 random run halted", halted, 1);
      check(int'(mem[12'h120]) == acks, "R7 entries match acks", mem[12'h120], acks);
      check(mem[12'h102] == int_expect(ra, rb), "R8 random result", mem[12'h102],
            int_expect(ra, rb));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule